// File: doc/BRIEF.md
# Flip-Flop State Occupancy Profiler

The profiler watches the data input and the stored output of a group of observed flip-flops. On every sampled clock it puts each flip-flop into one of four classes, chosen by the pair of values on its data input and its output. It adds the number of flip-flops found in each class to a saturating occupancy counter. A companion counter adds the group size on every sampled clock, so at the end of a window it holds the total number of flip-flop samples. Dividing each class count by that total gives the fraction of time spent in each class.

The host pulses `start_i` to clear everything and open a measurement window. It pulses `stop_i` to close the window. At the stop edge the four per-class sensitivity weights on `weights_i` are captured. The block then multiplies each class count by its weight and adds the products, one product per clock. The result is a weighted cross-section figure in fixed-point units. Scaling by a fault-injection ratio and any division are left to the host. The result and the sample total stay on the outputs until the next start.

Top module: `ffprof_top`

## Requirements
- R1: Each observed flip-flop i gets the 2-bit class code {ff_d_i[i], ff_q_i[i]}. Code 0 means both low, code 1 means data low and output high, code 2 means data high and output low, and code 3 means both high. The count for code k is presented on occ_cnt_o[k*CNT_W +: CNT_W].
- R2: On each sampled edge, every class count grows by the number of observed flip-flops whose code equals that class.
- R3: Each class count and the sample total saturate at 2^CNT_W-1 and never wrap.
- R4: On each sampled edge the sample total grows by N_FF. While the total is below saturation it equals the sum of the four class counts, and it never decreases except at a start.
- R5: A start pulse clears the class counts, the total and the result, and it opens the window (window_open_o=1 on the next cycle). The start edge itself is not sampled. When start and stop arrive together, start wins.
- R6: A stop pulse while the window is open closes it, and the stop edge is not sampled. While the window is closed the counts and the total stay unchanged. A stop while the window is closed has no effect.
- R7: weights_i carries weight k on weights_i[k*WGT_W +: WGT_W]. It is captured at the stop edge, and later changes have no effect on the result.
- R8: result_o becomes the sum over k of count_k times weight_k. done_o is high for exactly one cycle, on the fourth rising edge after the stop edge, and result_o is valid from that cycle on.
- R9: result_o and total_o hold their values after done until the next start.
- R10: A start during the computation abandons it. done_o does not assert and result_o reads zero.
- R11: After reset all counts, the total and the result are zero, and window_open_o, busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear counters and open window |
| stop_i | input | 1 | Close window and begin weighted sum |
| ff_d_i | input | N_FF (16) | Data inputs of observed flip-flops |
| ff_q_i | input | N_FF (16) | Outputs of observed flip-flops |
| weights_i | input | 4*WGT_W (64) | Per-class sensitivity weights, class k at slice k |
| window_open_o | output | 1 | Window currently sampling |
| busy_o | output | 1 | Weighted sum in progress |
| done_o | output | 1 | One-cycle completion pulse |
| occ_cnt_o | output | 4*CNT_W (128) | Class occupancy counts, class k at slice k |
| total_o | output | CNT_W (32) | Total flip-flop samples in window |
| result_o | output | ACC_W (64) | Weighted sum of class counts |

## Verification
The bench drives bit patterns that place flip-flops in every class at once and checks each class count. This catches a design that swaps the data and output bits, because such a design would exchange the code-1 and code-2 counts. It keeps stop and start asserted alongside non-zero patterns, so a design that samples on those edges would show counts larger by one pattern. It changes the weights right after stop, so a design that reads live weights gives the wrong sum. It also runs long enough to saturate a small counter, where a wrapping counter would read a small value. Finally it restarts in the middle of a computation and watches for a stray done pulse or a leftover result.

// File: rtl/ffprof_pkg.sv
package ffprof_pkg;

    localparam int OCC_CLASSES = 4;

    // Class code of one flip-flop: {data, output}
    typedef enum logic [1:0] {
        OCC_LOW_LOW   = 2'b00,
        OCC_LOW_HIGH  = 2'b01,
        OCC_HIGH_LOW  = 2'b10,
        OCC_HIGH_HIGH = 2'b11
    } occ_code_e;

    // Per-cycle window control decoded from the host pulses
    typedef struct packed {
        logic clear;
        logic sample;
        logic go;
    } win_ctrl_t;

    function automatic occ_code_e occ_encode(input logic d, input logic q);
        return occ_code_e'({d, q});
    endfunction

endpackage

// File: rtl/ffprof_classify.sv
module ffprof_classify
    import ffprof_pkg::*;
#(
    parameter int N_FF = 16,
    parameter int PC_W = 5
) (
    input  logic [N_FF-1:0]             d_i,
    input  logic [N_FF-1:0]             q_i,
    output logic [OCC_CLASSES*PC_W-1:0] pop_o
);

    for (genvar k = 0; k < OCC_CLASSES; k++) begin : g_cls
        logic [PC_W-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int i = 0; i < N_FF; i++) begin
                logic [1:0] code;
                code = occ_encode(d_i[i], q_i[i]);
                if (code == 2'(k)) cnt = cnt + PC_W'(1);
            end
        end
        assign pop_o[k*PC_W +: PC_W] = cnt;
    end

endmodule

// File: rtl/ffprof_counters.sv
module ffprof_counters
    import ffprof_pkg::*;
#(
    parameter int N_FF  = 16,
    parameter int CNT_W = 32,
    parameter int PC_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear_i,
    input  logic                         sample_i,
    input  logic [OCC_CLASSES*PC_W-1:0]  pop_i,
    output logic [OCC_CLASSES*CNT_W-1:0] occ_cnt_o,
    output logic [CNT_W-1:0]             total_o
);

    localparam int LANES = OCC_CLASSES + 1;
    localparam logic [CNT_W:0] SAT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [LANES-1:0][CNT_W-1:0] lane_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [CNT_W:0] inc;
        logic [CNT_W:0] sum;

        if (k < OCC_CLASSES) begin : g_occ
            assign inc = (CNT_W+1)'(pop_i[k*PC_W +: PC_W]);
        end else begin : g_tot
            assign inc = (CNT_W+1)'(N_FF);
        end

        assign sum = {1'b0, lane_q[k]} + inc;

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                lane_q[k] <= '0;
            end else if (sample_i) begin
                lane_q[k] <= (sum > SAT_MAX) ? SAT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
            end
        end

        if (k < OCC_CLASSES) begin : g_out
            assign occ_cnt_o[k*CNT_W +: CNT_W] = lane_q[k];
        end
    end

    assign total_o = lane_q[OCC_CLASSES];

endmodule

// File: rtl/ffprof_mac.sv
module ffprof_mac
    import ffprof_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int WGT_W = 16,
    parameter int ACC_W = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         abort_i,
    input  logic                         go_i,
    input  logic [OCC_CLASSES*WGT_W-1:0] weights_i,
    input  logic [OCC_CLASSES*CNT_W-1:0] occ_cnt_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [ACC_W-1:0]             result_o
);

    localparam int IDX_W = $clog2(OCC_CLASSES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OCC_CLASSES - 1);

    logic [OCC_CLASSES*WGT_W-1:0] wgt_q;
    logic [IDX_W-1:0]             idx_q;
    logic [ACC_W-1:0]             acc_q;
    logic [CNT_W-1:0]             cnt_sel;
    logic [WGT_W-1:0]             wgt_sel;
    logic [ACC_W-1:0]             term;

    assign cnt_sel = occ_cnt_i[idx_q*CNT_W +: CNT_W];
    assign wgt_sel = wgt_q[idx_q*WGT_W +: WGT_W];
    assign term    = ACC_W'(cnt_sel) * ACC_W'(wgt_sel);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            wgt_q    <= '0;
            idx_q    <= '0;
            acc_q    <= '0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                wgt_q  <= weights_i;
                idx_q  <= '0;
                acc_q  <= '0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                acc_q <= acc_q + term;
                idx_q <= idx_q + IDX_W'(1);
                if (idx_q == LAST_IDX) begin
                    busy_o   <= 1'b0;
                    done_o   <= 1'b1;
                    result_o <= acc_q + term;
                end
            end
        end
    end

endmodule

// File: rtl/ffprof_top.sv
module ffprof_top
    import ffprof_pkg::*;
#(
    parameter int N_FF  = 16,
    parameter int CNT_W = 32,
    parameter int WGT_W = 16,
    parameter int ACC_W = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic                         stop_i,
    input  logic [N_FF-1:0]              ff_d_i,
    input  logic [N_FF-1:0]              ff_q_i,
    input  logic [OCC_CLASSES*WGT_W-1:0] weights_i,
    output logic                         window_open_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [OCC_CLASSES*CNT_W-1:0] occ_cnt_o,
    output logic [CNT_W-1:0]             total_o,
    output logic [ACC_W-1:0]             result_o
);

    localparam int PC_W = $clog2(N_FF + 1);

    win_ctrl_t                    ctrl;
    logic [OCC_CLASSES*PC_W-1:0]  pop;

    always_comb begin
        ctrl.clear  = start_i;
        ctrl.sample = window_open_o && !start_i && !stop_i;
        ctrl.go     = window_open_o && stop_i && !start_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            window_open_o <= 1'b0;
        end else if (start_i) begin
            window_open_o <= 1'b1;
        end else if (stop_i) begin
            window_open_o <= 1'b0;
        end
    end

    ffprof_classify #(
        .N_FF (N_FF),
        .PC_W (PC_W)
    ) u_classify (
        .d_i   (ff_d_i),
        .q_i   (ff_q_i),
        .pop_o (pop)
    );

    ffprof_counters #(
        .N_FF  (N_FF),
        .CNT_W (CNT_W),
        .PC_W  (PC_W)
    ) u_counters (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (ctrl.clear),
        .sample_i  (ctrl.sample),
        .pop_i     (pop),
        .occ_cnt_o (occ_cnt_o),
        .total_o   (total_o)
    );

    ffprof_mac #(
        .CNT_W (CNT_W),
        .WGT_W (WGT_W),
        .ACC_W (ACC_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .abort_i   (ctrl.clear),
        .go_i      (ctrl.go),
        .weights_i (weights_i),
        .occ_cnt_i (occ_cnt_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

endmodule

// File: rtl/ffprof_chk.sv
module ffprof_chk
    import ffprof_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int ACC_W = 64
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start_i,
    input logic                         window_open_o,
    input logic                         busy_o,
    input logic                         done_o,
    input logic [OCC_CLASSES*CNT_W-1:0] occ_cnt_o,
    input logic [CNT_W-1:0]             total_o,
    input logic [ACC_W-1:0]             result_o
);

    logic [CNT_W+2:0] occ_sum;
    always_comb begin
        occ_sum = '0;
        for (int k = 0; k < OCC_CLASSES; k++)
            occ_sum = occ_sum + (CNT_W+3)'(occ_cnt_o[k*CNT_W +: CNT_W]);
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_closed_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!window_open_o && !busy_o));

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!window_open_o && !start_i) |=> ($stable(occ_cnt_o) && $stable(total_o)));

    p_start_clear_r5: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (window_open_o && total_o == '0 && occ_cnt_o == '0 && result_o == '0));

    p_sum_total_r4: assert property (@(posedge clk) disable iff (rst)
        (total_o != {CNT_W{1'b1}}) |-> (occ_sum == (CNT_W+3)'(total_o)));

    p_total_monotone_r4: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (total_o >= $past(total_o)));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !busy_o) |=> $stable(result_o));

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && !busy_o));

endmodule

bind ffprof_top ffprof_chk #(
    .CNT_W (CNT_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .window_open_o (window_open_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .occ_cnt_o     (occ_cnt_o),
    .total_o       (total_o),
    .result_o      (result_o)
);

// File: tb/tb_ffprof_top.sv
`timescale 1ns/1ps
module tb_ffprof_top;

    localparam int N_FF  = 8;
    localparam int CNT_W = 10;
    localparam int WGT_W = 16;
    localparam int ACC_W = 64;
    localparam longint SAT = (64'd1 << CNT_W) - 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic                 stop_i = 1'b0;
    logic [N_FF-1:0]      ff_d_i = '0;
    logic [N_FF-1:0]      ff_q_i = '0;
    logic [4*WGT_W-1:0]   weights_i = '0;
    logic                 window_open_o, busy_o, done_o;
    logic [4*CNT_W-1:0]   occ_cnt_o;
    logic [CNT_W-1:0]     total_o;
    logic [ACC_W-1:0]     result_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    longint exp_cnt [4];
    longint exp_tot;

    always #10 clk = ~clk;

    ffprof_top #(.N_FF(N_FF), .CNT_W(CNT_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .ff_d_i(ff_d_i), .ff_q_i(ff_q_i), .weights_i(weights_i),
        .window_open_o(window_open_o), .busy_o(busy_o), .done_o(done_o),
        .occ_cnt_o(occ_cnt_o), .total_o(total_o), .result_o(result_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        for (int k = 0; k < 4; k++)
            chk(req, longint'(occ_cnt_o[k*CNT_W +: CNT_W]), exp_cnt[k]);
        chk(req, longint'(total_o), exp_tot);
    endtask

    task automatic open_window();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
        exp_tot = 0;
    endtask

    task automatic sample(input logic [N_FF-1:0] d, input logic [N_FF-1:0] q);
        ff_d_i = d;
        ff_q_i = q;
        @(negedge clk);
        for (int i = 0; i < N_FF; i++) begin
            int code;
            code = {d[i], q[i]};
            exp_cnt[code] = exp_cnt[code] + 1;
        end
        for (int k = 0; k < 4; k++) if (exp_cnt[k] > SAT) exp_cnt[k] = SAT;
        exp_tot = exp_tot + N_FF;
        if (exp_tot > SAT) exp_tot = SAT;
    endtask

    function automatic longint wsum(input logic [4*WGT_W-1:0] w);
        longint s = 0;
        for (int k = 0; k < 4; k++) s += exp_cnt[k] * longint'(w[k*WGT_W +: WGT_W]);
        return s;
    endfunction

    // Close window with non-zero pattern present, then check the weighted sum timing
    task automatic close_and_sum(input logic [4*WGT_W-1:0] w, input string req);
        longint exp_res;
        weights_i = w;
        ff_d_i = '1; ff_q_i = '1;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        weights_i = ~w;          // R7: late change must be ignored
        exp_res = wsum(w);
        chk("R6 window closed", longint'(window_open_o), 0);
        chk_counts("R6 stop edge not sampled");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R8 done not early", longint'(done_o), 0);
        end
        @(negedge clk);
        chk("R8 done on fourth edge", longint'(done_o), 1);
        chk({req, " R7 R8 result"}, longint'(result_o), exp_res);
        @(negedge clk);
        chk("R8 done one cycle", longint'(done_o), 0);
    endtask

    task automatic t_reset();
        chk("R11 open", longint'(window_open_o), 0);
        chk("R11 busy", longint'(busy_o), 0);
        chk("R11 done", longint'(done_o), 0);
        chk("R11 counts", longint'(occ_cnt_o), 0);
        chk("R11 total", longint'(total_o), 0);
        chk("R11 result", longint'(result_o), 0);
    endtask

    task automatic t_classify();
        open_window();
        chk("R5 window open", longint'(window_open_o), 1);
        chk_counts("R5 start edge not sampled");
        sample(8'b1111_0000, 8'b1100_1100);
        chk_counts("R1 R2 mixed classes");
        sample(8'hFF, 8'h00);
        chk_counts("R1 code 2 data high output low");
        sample(8'h00, 8'hFF);
        chk_counts("R1 code 1 data low output high");
        sample(8'hA5, 8'h3C);
        chk_counts("R2 irregular pattern");
        close_and_sum({16'd7, 16'd300, 16'd11, 16'd2}, "classify");
    endtask

    task automatic t_hold_and_ignore();
        longint res_before, tot_before;
        res_before = longint'(result_o);
        tot_before = longint'(total_o);
        stop_i = 1'b1; ff_d_i = 8'h0F; ff_q_i = 8'hF0;
        @(negedge clk);
        stop_i = 1'b0;
        for (int c = 0; c < 6; c++) @(negedge clk);
        chk("R6 stop while closed no done", longint'(done_o), 0);
        chk("R6 R9 total held", longint'(total_o), tot_before);
        chk("R9 result held", longint'(result_o), res_before);
        chk_counts("R6 closed counts frozen");
    endtask

    task automatic t_saturate();
        open_window();
        for (int c = 0; c < 130; c++) sample(8'hFF, 8'hFF);
        chk_counts("R3 saturation");
        chk("R3 class 3 at max", longint'(occ_cnt_o[3*CNT_W +: CNT_W]), SAT);
        close_and_sum({16'd1000, 16'd1, 16'd1, 16'd1}, "saturate");
    endtask

    task automatic t_abort();
        open_window();
        sample(8'h3C, 8'h0F);
        sample(8'hC3, 8'hF0);
        stop_i = 1'b1;
        weights_i = {16'd5, 16'd5, 16'd5, 16'd5};
        @(negedge clk);
        stop_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
        exp_tot = 0;
        chk("R10 busy dropped", longint'(busy_o), 0);
        chk("R10 result cleared", longint'(result_o), 0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R10 no done", longint'(done_o), 0);
        end
        ff_d_i = '0; ff_q_i = '0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        for (int c = 0; c < 5; c++) @(negedge clk);
    endtask

    task automatic t_start_beats_stop();
        start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
        exp_tot = 0;
        chk("R5 start wins over stop", longint'(window_open_o), 1);
        sample(8'h01, 8'h03);
        chk_counts("R5 R2 sampling after combined pulse");
        close_and_sum({16'd9, 16'd8, 16'd7, 16'd6}, "restart");
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_classify();
        t_hold_and_ignore();
        t_saturate();
        t_abort();
        t_start_beats_stop();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule